// File: doc/BRIEF.md
# Named Warp Barrier Unit

This unit gives the warps of one thread block a bank of sixteen independent hardware barriers. A warp signals that it has reached a barrier by presenting one arrival request. The request names the warp, the barrier index, the expected participant count in threads, and a mode bit. The mode bit selects a blocking wait or a non-blocking arrive-only. The unit accepts at most one arrival per clock.

The unit counts arrivals per barrier at warp granularity. A participant count of N threads needs N/32 arrivals. Any warps may take part, wherever they sit in the block.

When the last arrival of a round is accepted, the unit pulses a per-warp release mask for one cycle. The mask names every warp that was waiting on that barrier. The barrier then re-arms itself, so later arrivals form a new round.

Arrivals that misuse a barrier are dropped and flagged. The unit raises its error flag in three cases:
- a warp that is still waiting arrives again;
- the count disagrees with the one latched for the current round;
- the count is not a positive multiple of 32.

Each barrier is a two-state machine:
- `BAR_IDLE` means no round is open.
- `BAR_GATHER` means a round is collecting arrivals.

Its transitions are:
- *open*: `BAR_IDLE` to `BAR_GATHER`, on a first arrival whose count needs more than one warp. The count is latched.
- *solo release*: `BAR_IDLE` to `BAR_IDLE`, on a first arrival whose count needs exactly one warp. The release happens at once.
- *accumulate*: `BAR_GATHER` to `BAR_GATHER`, on an arrival that is not the last one.
- *complete*: `BAR_GATHER` to `BAR_IDLE`, on the last arrival. This arrival releases the round and clears the round state.
- *reset*: any state to `BAR_IDLE`.

Top module: `warp_barrier_unit`

## Requirements
- R1: Sixteen barriers are selected by `arr_bar` (0 to 15), and arrivals on one index never count toward any other index.
- R2: A barrier whose round count is N threads releases on the N/32-th accepted arrival. A count of 32 releases on the arrival itself.
- R3: Any warps, contiguous or not, that arrive on the same index are counted together in one round.
- R4: For each released warp w, `release_mask[w]` is 1 for exactly one cycle. That cycle follows the clock edge that accepted the completing arrival. The released warps are those that arrived with `arr_mode`=0 (wait) in that round, including the completing warp when it waits.
- R5: After a release the barrier re-arms. The next arrival on that index opens a fresh round, which may latch a different count.
- R6: An arrival with `arr_mode`=1 (arrive-only) is counted, but its warp is never held and never appears in the release mask. An arrive-only completion with no waiters gives an all-zero mask.
- R7: Warps waiting on different indices never release each other. A group split across two indices stays waiting until each index completes on its own.
- R8: An arrival from a warp already waiting on any barrier is dropped and raises `err`.
- R9: An arrival whose count is zero or has a nonzero value in its low five bits is dropped and raises `err`.
- R10: An arrival whose count differs from the round's latched count is dropped and raises `err`. The open round continues unchanged.
- R11: Synchronous reset (`rst`=1) clears every waiting mask, arrival counter and latched count, and drives `release_mask` and `err` to 0.
- R12: `err` is high for exactly the one cycle after the edge that accepted the faulty request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arr_valid | input | 1 | Arrival request present this cycle |
| arr_warp | input | 5 | Arriving warp id |
| arr_bar | input | 4 | Barrier index |
| arr_count | input | 11 | Expected participant count in threads |
| arr_mode | input | 1 | 0 = wait for release, 1 = arrive only |
| release_mask | output | 32 | One-cycle release pulse per warp |
| err | output | 1 | One-cycle misuse flag |

## Verification
The bench goes after the following corner cases:
- A noncontiguous pair of warps completing a round. A design that ties participation to warp position would never release them.
- A second round on the same index with a larger count. A design that forgets to clear its counter would release one warp early.
- An arrive-only warp completing a round. A design that folds it into the mask would wrongly release it.
- A group split across two indices. A design that shares counters would release both halves too soon.
- A rejected count-mismatch arrival followed by a normal completion. A design that counts faulty requests would finish the round early.
- A reset in the middle of a round. A design that keeps its waiting mask would flag the restarted warp as a re-arrival.

// File: rtl/wbu_pkg.sv
package wbu_pkg;
    typedef enum logic {
        BAR_IDLE   = 1'b0,
        BAR_GATHER = 1'b1
    } bar_state_e;

    typedef enum logic {
        ARR_WAIT = 1'b0,
        ARR_ONLY = 1'b1
    } arr_mode_e;
endpackage

// File: rtl/arrival_screen.sv
module arrival_screen #(
    parameter int WARPS   = 32,
    parameter int BARS    = 16,
    parameter int COUNT_W = 11,
    parameter int LANES   = 32
) (
    input  logic                                                     valid,
    input  logic [$clog2(WARPS)-1:0]                                 warp,
    input  logic [$clog2(BARS)-1:0]                                  bar,
    input  logic [COUNT_W-1:0]                                       count,
    input  logic [WARPS-1:0]                                         wait_all,
    input  logic [BARS-1:0]                                          busy_all,
    input  logic [BARS-1:0][COUNT_W-$clog2(LANES)-1:0]               tgt_all,
    output logic [COUNT_W-$clog2(LANES)-1:0]                         tgt,
    output logic                                                     accept,
    output logic                                                     fault
);
    localparam int LANE_SH = $clog2(LANES);

    logic bad_count;
    logic rewait;
    logic mismatch;

    always_comb begin
        tgt       = count[COUNT_W-1:LANE_SH];
        bad_count = (count == '0) || (count[LANE_SH-1:0] != '0);
        rewait    = wait_all[warp];
        mismatch  = busy_all[bar] && (tgt_all[bar] != tgt);
        fault     = valid && (bad_count || rewait || mismatch);
        accept    = valid && !(bad_count || rewait || mismatch);
    end
endmodule

// File: rtl/bar_slice.sv
module bar_slice
    import wbu_pkg::*;
#(
    parameter int WARPS = 32,
    parameter int TGT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hit,
    input  logic [$clog2(WARPS)-1:0] warp,
    input  arr_mode_e                mode,
    input  logic [TGT_W-1:0]         tgt,
    output logic [WARPS-1:0]         wait_mask,
    output logic [WARPS-1:0]         rel_mask,
    output logic [TGT_W-1:0]         cur_tgt,
    output logic                     busy
);
    bar_state_e         state_q, state_n;
    logic [TGT_W-1:0]   arrived_q, arrived_n;
    logic [TGT_W-1:0]   tgt_q, tgt_n;
    logic [WARPS-1:0]   wait_q, wait_n;
    logic [WARPS-1:0]   own;

    assign own       = (mode == ARR_WAIT) ? (WARPS'(1) << warp) : '0;
    assign wait_mask = wait_q;
    assign cur_tgt   = tgt_q;
    assign busy      = (state_q == BAR_GATHER);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= BAR_IDLE;
            arrived_q <= '0;
            tgt_q     <= '0;
            wait_q    <= '0;
        end else begin
            state_q   <= state_n;
            arrived_q <= arrived_n;
            tgt_q     <= tgt_n;
            wait_q    <= wait_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state_q;
        arrived_n = arrived_q;
        tgt_n     = tgt_q;
        wait_n    = wait_q;
        rel_mask  = '0;
        unique case (state_q)
            BAR_IDLE: begin
                if (hit) begin
                    if (tgt == TGT_W'(1)) begin
                        rel_mask = own;                 // solo release
                    end else begin
                        state_n   = BAR_GATHER;         // open
                        arrived_n = TGT_W'(1);
                        tgt_n     = tgt;
                        wait_n    = own;
                    end
                end
            end
            BAR_GATHER: begin
                if (hit) begin
                    if ((arrived_q + TGT_W'(1)) == tgt_q) begin
                        rel_mask  = wait_q | own;       // complete
                        state_n   = BAR_IDLE;
                        arrived_n = '0;
                        tgt_n     = '0;
                        wait_n    = '0;
                    end else begin
                        arrived_n = arrived_q + TGT_W'(1);  // accumulate
                        wait_n    = wait_q | own;
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/warp_barrier_unit.sv
module warp_barrier_unit
    import wbu_pkg::*;
#(
    parameter int WARPS   = 32,
    parameter int BARS    = 16,
    parameter int COUNT_W = 11,
    parameter int LANES   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     arr_valid,
    input  logic [$clog2(WARPS)-1:0] arr_warp,
    input  logic [$clog2(BARS)-1:0]  arr_bar,
    input  logic [COUNT_W-1:0]       arr_count,
    input  logic                     arr_mode,
    output logic [WARPS-1:0]         release_mask,
    output logic                     err
);
    localparam int LANE_SH = $clog2(LANES);
    localparam int TGT_W   = COUNT_W - LANE_SH;
    localparam int BAR_W   = $clog2(BARS);

    logic                        accept;
    logic                        fault;
    logic [TGT_W-1:0]            tgt;
    logic [BARS-1:0]             busy_all;
    logic [BARS-1:0][TGT_W-1:0]  tgt_all;
    logic [BARS-1:0][WARPS-1:0]  wait_each;
    logic [BARS-1:0][WARPS-1:0]  rel_each;
    logic [WARPS-1:0]            wait_all;
    logic [WARPS-1:0]            rel_all;

    arrival_screen #(
        .WARPS(WARPS), .BARS(BARS), .COUNT_W(COUNT_W), .LANES(LANES)
    ) u_screen (
        .valid    (arr_valid),
        .warp     (arr_warp),
        .bar      (arr_bar),
        .count    (arr_count),
        .wait_all (wait_all),
        .busy_all (busy_all),
        .tgt_all  (tgt_all),
        .tgt      (tgt),
        .accept   (accept),
        .fault    (fault)
    );

    for (genvar g = 0; g < BARS; g++) begin : g_bar
        bar_slice #(.WARPS(WARPS), .TGT_W(TGT_W)) u_slice (
            .clk       (clk),
            .rst       (rst),
            .hit       (accept && (arr_bar == BAR_W'(g))),
            .warp      (arr_warp),
            .mode      (arr_mode_e'(arr_mode)),
            .tgt       (tgt),
            .wait_mask (wait_each[g]),
            .rel_mask  (rel_each[g]),
            .cur_tgt   (tgt_all[g]),
            .busy      (busy_all[g])
        );
    end

    always_comb begin
        wait_all = '0;
        rel_all  = '0;
        for (int b = 0; b < BARS; b++) begin
            wait_all = wait_all | wait_each[b];
            rel_all  = rel_all | rel_each[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            release_mask <= '0;
            err          <= 1'b0;
        end else begin
            release_mask <= rel_all;
            err          <= fault;
        end
    end
endmodule

// File: rtl/warp_barrier_unit_chk.sv
module warp_barrier_unit_chk #(
    parameter int WARPS   = 32,
    parameter int COUNT_W = 11,
    parameter int LANES   = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     arr_valid,
    input logic [$clog2(WARPS)-1:0] arr_warp,
    input logic [COUNT_W-1:0]       arr_count,
    input logic                     arr_mode,
    input logic [WARPS-1:0]         release_mask,
    input logic                     err,
    input logic [WARPS-1:0]         wait_all
);
    localparam int LANE_SH = $clog2(LANES);

    // R12: an error pulse always traces back to a request one cycle earlier
    p_err_cause_r12: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(arr_valid));

    // R9: malformed count is flagged
    p_bad_count_r9: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && ((arr_count == '0) || (arr_count[LANE_SH-1:0] != '0))) |=> err);

    // R8: a waiting warp arriving again is flagged
    p_rewait_r8: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && wait_all[arr_warp]) |=> err);

    // R4: releases only follow an arrival
    p_rel_cause_r4: assert property (@(posedge clk) disable iff (rst)
        (release_mask != '0) |-> $past(arr_valid));

    // R5: released warps are no longer held once the pulse is out
    p_rearm_r5: assert property (@(posedge clk) disable iff (rst)
        (release_mask != '0) |-> ((release_mask & wait_all) == '0));

    // R2: a one-warp count in wait mode releases at once unless rejected
    p_solo_r2: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && !arr_mode && !wait_all[arr_warp] && (arr_count == COUNT_W'(LANES)))
        |=> (release_mask[$past(arr_warp)] || err));
endmodule

bind warp_barrier_unit warp_barrier_unit_chk #(
    .WARPS(WARPS), .COUNT_W(COUNT_W), .LANES(LANES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .arr_valid    (arr_valid),
    .arr_warp     (arr_warp),
    .arr_count    (arr_count),
    .arr_mode     (arr_mode),
    .release_mask (release_mask),
    .err          (err),
    .wait_all     (wait_all)
);

// File: tb/test_warp_barrier_unit.sv
`timescale 1ns/1ps
module test_warp_barrier_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arr_valid = 1'b0;
    logic [4:0]  arr_warp = '0;
    logic [3:0]  arr_bar = '0;
    logic [10:0] arr_count = '0;
    logic        arr_mode = 1'b0;
    logic [31:0] release_mask;
    logic        err;

    int applied = 0;
    int bad     = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    warp_barrier_unit i_warp_barrier_unit (
        .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_warp(arr_warp),
        .arr_bar(arr_bar), .arr_count(arr_count), .arr_mode(arr_mode),
        .release_mask(release_mask), .err(err)
    );

    typedef struct packed {
        logic        vld;
        logic [4:0]  w;
        logic [3:0]  b;
        logic [10:0] c;
        logic        m;
        logic [31:0] rel;
        logic        e;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'd3,  4'd2,  11'd64,  1'b0, 32'h0,        1'b0, 4'd2},  // R2 first of two
        '{1'b1, 5'd9,  4'd2,  11'd64,  1'b0, 32'h0000_0208, 1'b0, 4'd3},  // R3 R4 noncontiguous pair
        '{1'b1, 5'd3,  4'd2,  11'd96,  1'b0, 32'h0,        1'b0, 4'd5},  // R5 new round, new count
        '{1'b1, 5'd20, 4'd2,  11'd96,  1'b1, 32'h0,        1'b0, 4'd6},  // R6 arrive-only counted
        '{1'b1, 5'd7,  4'd5,  11'd64,  1'b0, 32'h0,        1'b0, 4'd1},  // R1 other index
        '{1'b1, 5'd31, 4'd2,  11'd96,  1'b0, 32'h8000_0008, 1'b0, 4'd6},  // R6 20 not released
        '{1'b1, 5'd7,  4'd9,  11'd32,  1'b0, 32'h0,        1'b1, 4'd8},  // R8 re-arrival
        '{1'b1, 5'd0,  4'd5,  11'd64,  1'b0, 32'h0000_0081, 1'b0, 4'd1},  // R1 index 5 completes
        '{1'b1, 5'd1,  4'd4,  11'd64,  1'b0, 32'h0,        1'b0, 4'd7},  // R7 half on 4
        '{1'b1, 5'd2,  4'd6,  11'd64,  1'b0, 32'h0,        1'b0, 4'd7},  // R7 half on 6
        '{1'b0, 5'd0,  4'd0,  11'd0,   1'b0, 32'h0,        1'b0, 4'd7},  // R7 stays held
        '{1'b1, 5'd4,  4'd4,  11'd0,   1'b0, 32'h0,        1'b1, 4'd9},  // R9 zero count
        '{1'b1, 5'd4,  4'd4,  11'd48,  1'b0, 32'h0,        1'b1, 4'd9},  // R9 not multiple
        '{1'b1, 5'd4,  4'd4,  11'd96,  1'b0, 32'h0,        1'b1, 4'd10}, // R10 mismatch
        '{1'b0, 5'd0,  4'd0,  11'd0,   1'b0, 32'h0,        1'b0, 4'd12}, // R12 single pulse
        '{1'b1, 5'd4,  4'd4,  11'd64,  1'b1, 32'h0000_0002, 1'b0, 4'd10}, // R10 round intact
        '{1'b1, 5'd5,  4'd6,  11'd64,  1'b0, 32'h0000_0024, 1'b0, 4'd7},  // R7 index 6 alone
        '{1'b1, 5'd10, 4'd15, 11'd32,  1'b0, 32'h0000_0400, 1'b0, 4'd2},  // R2 count 32, index 15
        '{1'b1, 5'd10, 4'd15, 11'd32,  1'b1, 32'h0,        1'b0, 4'd6},  // R6 empty release
        '{1'b0, 5'd0,  4'd0,  11'd0,   1'b0, 32'h0,        1'b0, 4'd4}   // R4 pulse gone
    };

    task automatic check(input logic [31:0] exp_rel, input logic exp_err, input int req);
        applied++;
        if (release_mask !== exp_rel || err !== exp_err) begin
            bad++;
            $display("FAIL R%0d: release_mask=%h err=%b, expected %h err=%b",
                     req, release_mask, err, exp_rel, exp_err);
        end
    endtask

    task automatic apply(input vec_t v);
        arr_valid = v.vld;
        arr_warp  = v.w;
        arr_bar   = v.b;
        arr_count = v.c;
        arr_mode  = v.m;
        @(negedge clk);
        check(v.rel, v.e, int'(v.req));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(32'h0, 1'b0, 11);        // R11 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R11 reset mid-round
        apply('{1'b1, 5'd12, 4'd3, 11'd64, 1'b0, 32'h0, 1'b0, 4'd11});
        arr_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(32'h0, 1'b0, 11);
        rst = 1'b0;
        apply('{1'b1, 5'd13, 4'd3, 11'd64, 1'b0, 32'h0, 1'b0, 4'd11});
        apply('{1'b1, 5'd12, 4'd3, 11'd64, 1'b0, 32'h0000_3000, 1'b0, 4'd11});
        apply('{1'b0, 5'd0, 4'd0, 11'd0, 1'b0, 32'h0, 1'b0, 4'd4});
        summary();
    end
endmodule